// File: doc/BRIEF.md
# Level-Sensitive Interrupt Recognition Unit

This unit decides, for a small 8-bit processor core, when a maskable interrupt is taken. The request line is active low and level sensitive. A peripheral holds it low until software acknowledges the peripheral, so the unit never looks for edges.

The unit does not test the line at the instruction boundary. It samples the line once per instruction, near the end of that instruction, and keeps the result in a pending latch. Normally the sample is taken on the cycle before the final cycle. Instructions that flag early sampling are sampled one cycle before that. At the boundary, the unit starts interrupt entry if the latch is set and the mask flag is clear. Otherwise the core fetches the next opcode.

The mask flag is set by reset, by interrupt entry and by a set-mask instruction. A clear-mask instruction clears it, which allows nested interrupts. A return-from-interrupt reloads it with the saved value. The sequencer around the unit supplies the current cycle index and length of the instruction, and strobes the boundary and the mask operations.

Top module: `irq_sample_unit`

## Requirements
- R1: While `rst_n` is low, `mask_flag` reads 1 and the pending latch is cleared, so `irq_take` stays 0 until a sample point after reset finds the line low.
- R2: With `early_smp` low, the pending latch takes the value of "line low" on the cycle where `cyc_idx` equals `cyc_len`-2. The level of `irq_n` on every other cycle of the instruction has no effect on `irq_take`.
- R3: With `early_smp` high and `cyc_len` of at least 3, the sample point moves to `cyc_idx` = `cyc_len`-3, and the level at `cyc_len`-2 is ignored. For a 2-cycle instruction, `early_smp` has no effect.
- R4: `irq_take` is high during a cycle exactly when `insn_end` is high, the pending latch is set and `mask_flag` is 0. `insn_end` marks the final cycle (`cyc_idx` = `cyc_len`-1).
- R5: In the cycle after `irq_take` is high, `mask_flag` is 1. This holds even if a mask operation is strobed in the same cycle.
- R6: Mask operations take effect in the following cycle. Their priority is: interrupt entry, then `rti_pop` (which loads `rti_mask`), then `clr_mask` (which clears), then `set_mask` (which sets). A mask change made at a boundary does not affect the decision at that same boundary.
- R7: The pending latch is cleared at every boundary and is recomputed at every sample point. If the line returns high before the sample point, no interrupt is taken, and no request carries over into the next instruction.
- R8: While a stream of 2-cycle instructions runs with the mask clear, `irq_take` rises 1 or 2 cycles after the cycle in which `irq_n` falls. The spread is therefore one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 1 | Active-low level-sensitive interrupt request |
| cyc_idx | input | CYC_W | Zero-based cycle index within the current instruction |
| cyc_len | input | CYC_W | Total cycle count of the current instruction |
| early_smp | input | 1 | Current instruction samples the line one cycle earlier |
| insn_end | input | 1 | Final cycle of the current instruction (boundary) |
| set_mask | input | 1 | Set-mask instruction completes this cycle |
| clr_mask | input | 1 | Clear-mask instruction completes this cycle |
| rti_pop | input | 1 | Return-from-interrupt restores the mask this cycle |
| rti_mask | input | 1 | Saved mask value restored by `rti_pop` |
| irq_take | output | 1 | Start interrupt entry instead of the next opcode fetch |
| mask_flag | output | 1 | Current interrupt-disable flag |

## Verification
Two cases are hard to reach from the ports.

- **Early versus normal sampling.** Telling the early sample point from the normal one needs a request line that is low on exactly one cycle of an instruction. The directed part of the bench therefore drives one per-cycle line pattern per instruction, with the line low only at `cyc_len`-3 or only at `cyc_len`-2, with and without `early_smp`.
- **Entry jitter.** Measuring the jitter bound needs the falling edge to land on every phase of a 2-cycle instruction stream. A series of trials therefore places the fall at random offsets and measures the cycle distance to `irq_take`.

A random phase of mixed-length instructions, mask operations and line toggles is compared cycle by cycle against a reference model built from the sampling rule.

// File: rtl/irq_smp_pkg.sv
package irq_smp_pkg;

   // Mask register update selected for one cycle
   typedef enum logic [1:0] {
      MASK_KEEP = 2'd0,
      MASK_SET  = 2'd1,
      MASK_CLR  = 2'd2,
      MASK_LOAD = 2'd3
   } mask_op_e;

   // Priority: entry > return restore > clear > set
   function automatic mask_op_e pick_mask_op(input logic take,
                                             input logic rti_pop,
                                             input logic clr,
                                             input logic set);
      mask_op_e op;
      if (take)         op = MASK_SET;
      else if (rti_pop) op = MASK_LOAD;
      else if (clr)     op = MASK_CLR;
      else if (set)     op = MASK_SET;
      else              op = MASK_KEEP;
      return op;
   endfunction

endpackage

// File: rtl/irq_smp_point.sv
module irq_smp_point #(
   parameter int CYC_W    = 3,
   parameter bit EARLY_EN = 1'b1
) (
   input  logic [CYC_W-1:0] cyc_idx,
   input  logic [CYC_W-1:0] cyc_len,
   input  logic             early_smp,
   output logic             smp_stb
);
   localparam logic [CYC_W-1:0] LATE_OFS  = CYC_W'(2);
   localparam logic [CYC_W-1:0] EARLY_OFS = CYC_W'(3);

   if (CYC_W < 2) begin : g_bad_width
      $error("irq_smp_point: CYC_W must be at least 2");
   end

   logic [CYC_W-1:0] late_pt;
   assign late_pt = cyc_len - LATE_OFS;

   if (EARLY_EN) begin : g_early
      logic [CYC_W-1:0] early_pt;
      logic             early_ok;
      assign early_pt = cyc_len - EARLY_OFS;
      // 2-cycle instructions fall back to the normal point
      assign early_ok = early_smp && (cyc_len >= EARLY_OFS);
      assign smp_stb  = early_ok ? (cyc_idx == early_pt) : (cyc_idx == late_pt);
   end else begin : g_late_only
      logic early_unused;
      assign early_unused = early_smp;
      assign smp_stb      = (cyc_idx == late_pt) | (early_unused & 1'b0);
   end

endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_stb,
   input  logic line_act,
   input  logic insn_end,
   output logic pend
);

   always_ff @(posedge clk) begin
      if (!rst_n)        pend <= 1'b0;
      else if (insn_end) pend <= 1'b0;
      else if (smp_stb)  pend <= line_act;
   end

   AST_PEND_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      insn_end |=> !pend) else $error("pending survived boundary"); // R7

   AST_PEND_TRACKS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb && !insn_end |=> pend == $past(line_act)) else $error("sample lost"); // R2

   AST_PEND_HOLDS_OFF_POINT: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb && !insn_end |=> $stable(pend)) else $error("line leaked in"); // R2

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg import irq_smp_pkg::*; #(
   parameter bit RESET_MASK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic rti_pop,
   input  logic rti_mask,
   input  logic clr,
   input  logic set,
   output logic mask
);
   mask_op_e op;
   assign op = pick_mask_op(take, rti_pop, clr, set);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask <= RESET_MASK;
      end else begin
         case (op)
            MASK_SET:  mask <= 1'b1;
            MASK_CLR:  mask <= 1'b0;
            MASK_LOAD: mask <= rti_mask;
            default:   mask <= mask;
         endcase
      end
   end

   AST_RTI_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      rti_pop && !take |=> mask == $past(rti_mask)) else $error("restore lost"); // R6

   AST_CLR_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !rti_pop && !take |=> !mask) else $error("clear lost"); // R6

   AST_SET_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      set && !rti_pop && !clr |=> mask) else $error("set lost"); // R6

endmodule

// File: rtl/irq_sample_unit.sv
module irq_sample_unit import irq_smp_pkg::*; #(
   parameter int CYC_W      = 3,
   parameter bit EARLY_EN   = 1'b1,
   parameter bit RESET_MASK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_n,
   input  logic [CYC_W-1:0] cyc_idx,
   input  logic [CYC_W-1:0] cyc_len,
   input  logic             early_smp,
   input  logic             insn_end,
   input  logic             set_mask,
   input  logic             clr_mask,
   input  logic             rti_pop,
   input  logic             rti_mask,
   output logic             irq_take,
   output logic             mask_flag
);
   logic line_act;
   logic smp_stb;
   logic pend;

   assign line_act = ~irq_n;

   irq_smp_point #(.CYC_W(CYC_W), .EARLY_EN(EARLY_EN)) u_point (
      .cyc_idx  (cyc_idx),
      .cyc_len  (cyc_len),
      .early_smp(early_smp),
      .smp_stb  (smp_stb)
   );

   irq_pend_latch u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_stb (smp_stb),
      .line_act(line_act),
      .insn_end(insn_end),
      .pend    (pend)
   );

   irq_mask_reg #(.RESET_MASK(RESET_MASK)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (irq_take),
      .rti_pop (rti_pop),
      .rti_mask(rti_mask),
      .clr     (clr_mask),
      .set     (set_mask),
      .mask    (mask_flag)
   );

   assign irq_take = insn_end & pend & ~mask_flag;

   AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> mask_flag) else $error("entry left mask open"); // R5

endmodule

// File: tb/irq_sample_unit_bench.sv
module irq_sample_unit_bench;
   localparam int CW = 3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, irq_n, early_smp, insn_end, set_mask, clr_mask, rti_pop, rti_mask;
   logic [CW-1:0] cyc_idx, cyc_len;
   logic irq_take, mask_flag;

   irq_sample_unit #(.CYC_W(CW)) u_irq_sample_unit (
      .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .cyc_idx(cyc_idx), .cyc_len(cyc_len),
      .early_smp(early_smp), .insn_end(insn_end), .set_mask(set_mask),
      .clr_mask(clr_mask), .rti_pop(rti_pop), .rti_mask(rti_mask),
      .irq_take(irq_take), .mask_flag(mask_flag)
   );

   typedef struct {bit take; bit mask; string req;} exp_t;
   typedef enum {OP_NONE, OP_SEI, OP_CLI, OP_RTI} op_e;

   exp_t  sb_q[$];
   int    n_chk = 0, n_err = 0, cyc_cnt = 0;
   bit    ref_mask, ref_pend, last_take, prev_line;
   int    take_cyc, fall_cyc;
   string cur_req;

   always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Monitor: compares the design against queued expectations
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #3;
         if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            check(e.req, 32'(irq_take), 32'(e.take));
            check(e.req, 32'(mask_flag), 32'(e.mask));
            if (irq_take === 1'b1) begin
               last_take = 1'b1;
               take_cyc  = cyc_cnt;
            end
         end
      end
   end

   task automatic drive_idle();
      @(negedge clk);
      cyc_idx = '0; cyc_len = CW'(7); early_smp = 0; insn_end = 0;
      set_mask = 0; clr_mask = 0; rti_pop = 0; rti_mask = 0;
   endtask

   // Driver: one instruction, per-cycle line pattern, reference model
   task automatic run_insn(int len, bit early, op_e op, bit saved, bit [7:0] pat,
                           output bit took);
      int smp;
      bit fin, tk;
      took = 0;
      smp  = (early && len >= 3) ? len - 3 : len - 2;
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         fin = (k == len - 1);
         irq_n = pat[k];
         if (prev_line && !pat[k]) fall_cyc = cyc_cnt;
         prev_line = pat[k];
         cyc_idx = CW'(k); cyc_len = CW'(len); early_smp = early; insn_end = fin;
         set_mask = fin && op == OP_SEI;
         clr_mask = fin && op == OP_CLI;
         rti_pop  = fin && op == OP_RTI;
         rti_mask = saved;
         tk = fin && ref_pend && !ref_mask;
         sb_q.push_back('{tk, ref_mask, cur_req});
         if (tk) took = 1;
         if (tk)                         ref_mask = 1;
         else if (fin && op == OP_RTI)   ref_mask = saved;
         else if (fin && op == OP_CLI)   ref_mask = 0;
         else if (fin && op == OP_SEI)   ref_mask = 1;
         if (fin)           ref_pend = 0;
         else if (k == smp) ref_pend = !pat[k];
      end
   endtask

   task automatic expect_take(string req, bit exp);
      #5;
      check(req, 32'(last_take), 32'(exp));
      last_take = 0;
   endtask

   task automatic entry_and_return(bit saved);
      bit t;
      run_insn(7, 0, OP_NONE, 0, 8'hFF, t);
      run_insn(6, 0, OP_RTI, saved, 8'hFF, t);
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_err++;
      $display("FAIL R4 watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      bit t, lvl;
      bit [7:0] pat;
      int f, delta, len;
      op_e op;
      rst_n = 0; irq_n = 1; prev_line = 1; last_take = 0;
      cyc_idx = '0; cyc_len = CW'(7); early_smp = 0; insn_end = 0;
      set_mask = 0; clr_mask = 0; rti_pop = 0; rti_mask = 0;
      repeat (3) @(negedge clk);
      #3;
      check("R1", 32'(mask_flag), 1);
      check("R1", 32'(irq_take), 0);
      @(negedge clk); rst_n = 1;
      ref_mask = 1; ref_pend = 0;

      cur_req = "R1"; run_insn(2, 0, OP_NONE, 0, 8'h00, t); expect_take("R1", 0);
      cur_req = "R6"; run_insn(2, 0, OP_CLI, 0, 8'hFF, t); expect_take("R6", 0);
      // R2: low only at len-2
      cur_req = "R2"; run_insn(4, 0, OP_NONE, 0, 8'b1111_1011, t); expect_take("R2", 1);
      cur_req = "R5"; entry_and_return(0); expect_take("R5", 0);
      // R2: low only off the sample point
      cur_req = "R2"; run_insn(4, 0, OP_NONE, 0, 8'b1111_0101, t); expect_take("R2", 0);
      // R3: early point len-3
      cur_req = "R3"; run_insn(4, 1, OP_NONE, 0, 8'b1111_1101, t); expect_take("R3", 1);
      entry_and_return(0); last_take = 0;
      cur_req = "R3"; run_insn(4, 1, OP_NONE, 0, 8'b1111_1011, t); expect_take("R3", 0);
      cur_req = "R3"; run_insn(2, 1, OP_NONE, 0, 8'b1111_1110, t); expect_take("R3", 1);
      entry_and_return(0); last_take = 0;
      // R7: line released before the sample point, nothing carried
      cur_req = "R7"; run_insn(5, 0, OP_NONE, 0, 8'b1111_1100, t); expect_take("R7", 0);
      cur_req = "R7"; run_insn(3, 0, OP_NONE, 0, 8'hFF, t); expect_take("R7", 0);
      // R4/R6: masked, then clear at a boundary does not affect that boundary
      cur_req = "R4"; run_insn(2, 0, OP_SEI, 0, 8'hFF, t);
      run_insn(3, 0, OP_NONE, 0, 8'h00, t); expect_take("R4", 0);
      cur_req = "R6"; run_insn(2, 0, OP_CLI, 0, 8'h00, t); expect_take("R6", 0);
      cur_req = "R4"; run_insn(2, 0, OP_NONE, 0, 8'h00, t); expect_take("R4", 1);
      // R6: nested entry after a clear inside the handler
      cur_req = "R6"; run_insn(7, 0, OP_NONE, 0, 8'hFF, t);
      run_insn(2, 0, OP_CLI, 0, 8'hFF, t);
      last_take = 0;
      run_insn(3, 0, OP_NONE, 0, 8'h00, t); expect_take("R6", 1);
      entry_and_return(1); last_take = 0;
      check("R6", 32'(mask_flag), 1);
      run_insn(2, 0, OP_CLI, 0, 8'hFF, t);

      // R8: entry jitter over a 2-cycle stream
      cur_req = "R8";
      for (int trial = 0; trial < 16; trial++) begin
         f = $urandom_range(0, 7);
         t = 0;
         for (int n = 0; n < 10 && !t; n++) begin
            pat = 8'hFF;
            for (int k = 0; k < 2; k++) if (2 * n + k >= f) pat[k] = 1'b0;
            run_insn(2, 0, OP_NONE, 0, pat, t);
         end
         #5;
         delta = take_cyc - fall_cyc;
         check("R8", 32'(t && delta >= 1 && delta <= 2), 1);
         last_take = 0;
         entry_and_return(0); last_take = 0;
      end

      // R4: random mix against the reference model
      cur_req = "R4"; lvl = 1;
      for (int i = 0; i < 300; i++) begin
         len = $urandom_range(2, 7);
         pat = 8'hFF;
         for (int k = 0; k < 8; k++) begin
            if ($urandom_range(0, 5) == 0) lvl = !lvl;
            pat[k] = lvl;
         end
         case ($urandom_range(0, 7))
            0: op = OP_SEI;
            1, 2: op = OP_CLI;
            3: op = OP_RTI;
            default: op = OP_NONE;
         endcase
         run_insn(len, 1'($urandom_range(0, 1)), op, 1'($urandom_range(0, 1)), pat, t);
         if (t) run_insn(7, 0, OP_NONE, 0, pat, t);
      end
      drive_idle();
      #5;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule